// File: doc/BRIEF.md
# Freezable Performance Event Counter Unit

This block holds a bank of event counters, by default four of them, each 32 bits wide. A simple register port reads and writes every counter, its two local control words and one shared global control word. Each counter picks one line from a vector of single-cycle event pulses through its selector field. It adds one for every pulse it sees, except while a freeze applies. A freeze can come from the global freeze-all bit, from the counter's own stop bit, from the current privilege level, or from the processor mark signal.

A counter whose top bit is 1 is in overflow condition. To get a condition after N events, software loads the counter with 0x80000000 minus N. If the counter's condition-enable bit is set, the condition is passed to the global level. There it drives a level-sensitive interrupt while global interrupt enable is set. If freeze-on-condition is set, it also sets freeze-all in hardware. Every counter then holds the value it had when the interrupt was raised. To resume, software clears freeze-all and sets interrupt enable again.

Top module: `perf_event_unit`

## Requirements
- R1: After reset every counter reads 0, every local control A word reads 0x1F (all five freeze bits set, event select 0, condition enable 0), every local control B word reads 0, and the global word reads 0x1 (freeze-all set, interrupt enable and freeze-on-condition clear).
- R2: A counter adds exactly one on each clock edge where the event input chosen by its select field (control A bits [8 +: SEL_W]) is high and no freeze applies. Pulses on event inputs that are not selected leave the counter unchanged.
- R3: While control A bit 0 (local stop) is set, that counter holds its value.
- R4: Control A bit 1 freezes the counter while the privilege input is 1 (supervisor). Control A bit 2 freezes it while the privilege input is 0 (user).
- R5: Control A bit 3 freezes the counter while the mark input is 0. Control A bit 4 freezes it while the mark input is 1. With only bit 4 set, the counter counts only while mark is 0.
- R6: While global bit 0 (freeze-all) is set, no counter changes except through a register write.
- R7: A register write to a counter in the same cycle as a qualified event loads the written value, and the event is lost.
- R8: A counter is in overflow condition whenever its most significant bit is 1. If that counter's control A bit 5 (condition enable) is set and global bit 2 (freeze-on-condition) is set, freeze-all becomes 1 on the next clock edge. From then on all counters hold.
- R9: The interrupt output is 1 exactly when global bit 1 (interrupt enable) is set and at least one counter has both its MSB and its condition-enable bit set. The level stays for as long as those terms hold.
- R10: Addresses are {region[1:0], index}: region 0 is the global word, 1 the counters, 2 control A, 3 control B. Control B stores and returns any 32-bit value. Control A keeps only bits [5:0] and the select field, and reads other bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address {region, index} |
| reg_wdata | input | CTR_W | Write data |
| reg_rdata | output | CTR_W | Read data for reg_addr, combinational |
| evt_in | input | NUM_EVT | Single-cycle event pulses |
| priv_sup | input | 1 | Current privilege: 1 supervisor, 0 user |
| mark | input | 1 | Processor mark state |
| irq | output | 1 | Level-sensitive overflow interrupt |

## Verification
The bench crosses 0x7FFFFFFF to 0x80000000 with freeze-on-condition set, then pulses events on two counters. A design that froze too late, or froze only the overflowing counter, would let those counts move. It writes a counter in the same cycle as a qualified event, which catches an increment that wins over the write. It runs each freeze source against both values of its qualifying input, so a swapped privilege or mark polarity changes the count. It turns off interrupt enable and then condition enable while the overflow stays in place, so an interrupt that ignores either gate stays high.

// File: rtl/perf_pkg.sv
package perf_pkg;
   // local control A bit positions
   localparam int LA_STOP     = 0;
   localparam int LA_FRZ_SUP  = 1;
   localparam int LA_FRZ_USR  = 2;
   localparam int LA_FRZ_M0   = 3;
   localparam int LA_FRZ_M1   = 4;
   localparam int LA_CE       = 5;
   localparam int LA_SEL_LSB  = 8;
   // global control bit positions
   localparam int G_FA        = 0;
   localparam int G_IE        = 1;
   localparam int G_FCEC      = 2;
   localparam int G_W         = 3;

   typedef enum logic [1:0] {
      REG_GLOBAL = 2'd0,
      REG_COUNT  = 2'd1,
      REG_CTLA   = 2'd2,
      REG_CTLB   = 2'd3
   } reg_region_e;
endpackage

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice
   import perf_pkg::*;
#(
   parameter int CTR_W   = 32,
   parameter int NUM_EVT = 16,
   parameter int SEL_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               frz_all,
   input  logic               priv_sup,
   input  logic               mark,
   input  logic               wr_cnt,
   input  logic               wr_ctla,
   input  logic               wr_ctlb,
   input  logic [CTR_W-1:0]   wdata,
   output logic [CTR_W-1:0]   cnt_q,
   output logic [CTR_W-1:0]   ctla_q,
   output logic [CTR_W-1:0]   ctlb_q,
   output logic               cond
);
   localparam logic [CTR_W-1:0] CTLA_LOW  = CTR_W'((1 << (LA_CE + 1)) - 1);
   localparam logic [CTR_W-1:0] CTLA_SEL  = CTR_W'((1 << SEL_W) - 1) << LA_SEL_LSB;
   localparam logic [CTR_W-1:0] CTLA_MASK = CTLA_LOW | CTLA_SEL;
   localparam logic [CTR_W-1:0] CTLA_RST  = CTR_W'(32'h1F);
   localparam int               SEL_SPAN  = 1 << SEL_W;

   logic [SEL_W-1:0] sel;
   logic             evt_sel;
   logic             mode_frz;
   logic             mark_frz;
   logic             count_en;

   assign sel = ctla_q[LA_SEL_LSB +: SEL_W];

   generate
      if (SEL_SPAN == NUM_EVT) begin : g_sel_direct
         assign evt_sel = evt_in[sel];
      end else begin : g_sel_cmp
         always_comb begin
            evt_sel = 1'b0;
            for (int e = 0; e < NUM_EVT; e++) begin
               if (sel == SEL_W'(e)) evt_sel = evt_in[e];
            end
         end
      end
   endgenerate

   assign mode_frz = priv_sup ? ctla_q[LA_FRZ_SUP] : ctla_q[LA_FRZ_USR];
   assign mark_frz = mark ? ctla_q[LA_FRZ_M1] : ctla_q[LA_FRZ_M0];
   assign count_en = evt_sel & ~frz_all & ~ctla_q[LA_STOP] & ~mode_frz & ~mark_frz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_cnt) begin
         cnt_q <= wdata;
      end else if (count_en) begin
         cnt_q <= cnt_q + CTR_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctla_q <= CTLA_RST;
         ctlb_q <= '0;
      end else begin
         if (wr_ctla) ctla_q <= wdata & CTLA_MASK;
         if (wr_ctlb) ctlb_q <= wdata;
      end
   end

   assign cond = cnt_q[CTR_W-1] & ctla_q[LA_CE];
endmodule

// File: rtl/perf_global_ctl.sv
module perf_global_ctl
   import perf_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [G_W-1:0] wdata,
   input  logic           cond_any,
   output logic           frz_all,
   output logic           int_en,
   output logic           fcec
);
   logic fa_next;

   // hardware freeze is OR-ed over any software value written in the same cycle
   always_comb begin
      fa_next = wr ? wdata[G_FA] : frz_all;
      if (fcec && cond_any) fa_next = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frz_all <= 1'b1;
         int_en  <= 1'b0;
         fcec    <= 1'b0;
      end else begin
         frz_all <= fa_next;
         if (wr) begin
            int_en <= wdata[G_IE];
            fcec   <= wdata[G_FCEC];
         end
      end
   end
endmodule

// File: rtl/perf_reg_decode.sv
module perf_reg_decode
   import perf_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 32,
   parameter int IDX_W   = 2,
   parameter int ADDR_W  = 4
) (
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all,
   input  logic [NUM_CTR-1:0][CTR_W-1:0] ctla_all,
   input  logic [NUM_CTR-1:0][CTR_W-1:0] ctlb_all,
   input  logic [CTR_W-1:0]              glob_word,
   output logic [NUM_CTR-1:0]            wr_cnt,
   output logic [NUM_CTR-1:0]            wr_ctla,
   output logic [NUM_CTR-1:0]            wr_ctlb,
   output logic                          wr_glob,
   output logic [CTR_W-1:0]              rdata
);
   reg_region_e      region;
   logic [IDX_W-1:0] idx;

   assign region = reg_region_e'(addr[ADDR_W-1 -: 2]);
   assign idx    = addr[IDX_W-1:0];

   always_comb begin
      wr_glob = we && (region == REG_GLOBAL) && (idx == '0);
      for (int i = 0; i < NUM_CTR; i++) begin
         wr_cnt[i]  = we && (region == REG_COUNT) && (idx == IDX_W'(i));
         wr_ctla[i] = we && (region == REG_CTLA)  && (idx == IDX_W'(i));
         wr_ctlb[i] = we && (region == REG_CTLB)  && (idx == IDX_W'(i));
      end
   end

   always_comb begin
      rdata = '0;
      case (region)
         REG_GLOBAL: if (idx == '0) rdata = glob_word;
         REG_COUNT: for (int i = 0; i < NUM_CTR; i++) if (idx == IDX_W'(i)) rdata = cnt_all[i];
         REG_CTLA:  for (int i = 0; i < NUM_CTR; i++) if (idx == IDX_W'(i)) rdata = ctla_all[i];
         REG_CTLB:  for (int i = 0; i < NUM_CTR; i++) if (idx == IDX_W'(i)) rdata = ctlb_all[i];
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/perf_event_unit.sv
module perf_event_unit
   import perf_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 32,
   parameter int NUM_EVT = 16,
   parameter int SEL_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
   parameter int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
   parameter int ADDR_W  = IDX_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [CTR_W-1:0]   reg_wdata,
   output logic [CTR_W-1:0]   reg_rdata,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               priv_sup,
   input  logic               mark,
   output logic               irq
);
   generate
      if (NUM_CTR < 1) begin : g_bad_ctr
         $error("perf_event_unit: NUM_CTR must be at least 1");
      end
      if (CTR_W < LA_SEL_LSB + SEL_W) begin : g_bad_width
         $error("perf_event_unit: CTR_W too narrow for control A layout");
      end
      if ((1 << SEL_W) < NUM_EVT) begin : g_bad_sel
         $error("perf_event_unit: SEL_W cannot address every event input");
      end
      if (ADDR_W != IDX_W + 2) begin : g_bad_addr
         $error("perf_event_unit: ADDR_W must equal IDX_W + 2");
      end
   endgenerate

   logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all;
   logic [NUM_CTR-1:0][CTR_W-1:0] ctla_all;
   logic [NUM_CTR-1:0][CTR_W-1:0] ctlb_all;
   logic [NUM_CTR-1:0]            wr_cnt;
   logic [NUM_CTR-1:0]            wr_ctla;
   logic [NUM_CTR-1:0]            wr_ctlb;
   logic [NUM_CTR-1:0]            cond_vec;
   logic                          wr_glob;
   logic                          cond_any;
   logic                          frz_all;
   logic                          int_en;
   logic                          fcec;
   logic [CTR_W-1:0]              glob_word;

   perf_reg_decode #(
      .NUM_CTR (NUM_CTR),
      .CTR_W   (CTR_W),
      .IDX_W   (IDX_W),
      .ADDR_W  (ADDR_W)
   ) u_decode (
      .we        (reg_we),
      .addr      (reg_addr),
      .cnt_all   (cnt_all),
      .ctla_all  (ctla_all),
      .ctlb_all  (ctlb_all),
      .glob_word (glob_word),
      .wr_cnt    (wr_cnt),
      .wr_ctla   (wr_ctla),
      .wr_ctlb   (wr_ctlb),
      .wr_glob   (wr_glob),
      .rdata     (reg_rdata)
   );

   generate
      for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
         perf_ctr_slice #(
            .CTR_W   (CTR_W),
            .NUM_EVT (NUM_EVT),
            .SEL_W   (SEL_W)
         ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_in   (evt_in),
            .frz_all  (frz_all),
            .priv_sup (priv_sup),
            .mark     (mark),
            .wr_cnt   (wr_cnt[i]),
            .wr_ctla  (wr_ctla[i]),
            .wr_ctlb  (wr_ctlb[i]),
            .wdata    (reg_wdata),
            .cnt_q    (cnt_all[i]),
            .ctla_q   (ctla_all[i]),
            .ctlb_q   (ctlb_all[i]),
            .cond     (cond_vec[i])
         );
      end
   endgenerate

   assign cond_any = |cond_vec;

   perf_global_ctl u_global (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_glob),
      .wdata    (reg_wdata[G_W-1:0]),
      .cond_any (cond_any),
      .frz_all  (frz_all),
      .int_en   (int_en),
      .fcec     (fcec)
   );

   assign glob_word = {{(CTR_W-G_W){1'b0}}, fcec, int_en, frz_all};
   assign irq       = cond_any & int_en;
endmodule

// File: rtl/perf_event_unit_chk.sv
module perf_event_unit_chk #(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all,
   input logic [NUM_CTR-1:0]            wr_cnt,
   input logic                          frz_all,
   input logic                          fcec,
   input logic                          cond_any,
   input logic                          int_en,
   input logic                          irq
);
   logic [NUM_CTR-1:0] msb_vec;

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_msb
      assign msb_vec[i] = cnt_all[i][CTR_W-1];

      // R2
      step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_cnt[i] |=> (cnt_all[i] == $past(cnt_all[i])) ||
                        (cnt_all[i] == $past(cnt_all[i]) + CTR_W'(1)))
         else $error("counter %0d moved by more than one", i);

      // R6
      freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (frz_all && !wr_cnt[i]) |=> $stable(cnt_all[i]))
         else $error("counter %0d moved under freeze-all", i);
   end

   // R8
   auto_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fcec && cond_any) |=> frz_all)
      else $error("enabled condition did not set freeze-all");

   // R9
   irq_needs_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (msb_vec != '0))
      else $error("interrupt without any counter MSB set");

   // R9
   irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> int_en)
      else $error("interrupt while interrupt enable clear");
endmodule

bind perf_event_unit perf_event_unit_chk #(
   .NUM_CTR (NUM_CTR),
   .CTR_W   (CTR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_all  (cnt_all),
   .wr_cnt   (wr_cnt),
   .frz_all  (frz_all),
   .fcec     (fcec),
   .cond_any (cond_any),
   .int_en   (int_en),
   .irq      (irq)
);

// File: tb/perf_event_unit_bench.sv
module perf_event_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CTR    = 4;
   localparam int CTR_W      = 32;
   localparam int NUM_EVT    = 16;
   localparam int ADDR_W     = 4;

   localparam logic [3:0] A_GLOB = 4'h0;
   localparam logic [3:0] A_CNT  = 4'h4;
   localparam logic [3:0] A_CTLA = 4'h8;
   localparam logic [3:0] A_CTLB = 4'hC;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               reg_we = 1'b0;
   logic [ADDR_W-1:0]  reg_addr = '0;
   logic [CTR_W-1:0]   reg_wdata = '0;
   logic [CTR_W-1:0]   reg_rdata;
   logic [NUM_EVT-1:0] evt_in = '0;
   logic               priv_sup = 1'b1;
   logic               mark = 1'b0;
   logic               irq;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];
   logic  chk_req = 1'b0;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   perf_event_unit #(
      .NUM_CTR (NUM_CTR),
      .CTR_W   (CTR_W),
      .NUM_EVT (NUM_EVT)
   ) u_perf_event_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_in    (evt_in),
      .priv_sup  (priv_sup),
      .mark      (mark),
      .irq       (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: pops one expected item per requested sample
   always @(negedge clk) begin
      item_t       it;
      logic [31:0] got;
      if (chk_req && sb_q.size() > 0) begin
         it  = sb_q.pop_front();
         got = it.is_irq ? {31'b0, irq} : reg_rdata;
         n_chk++;
         if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
         end
      end
   end

   task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(posedge clk); #1;
      reg_addr = a;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      chk_req = 1'b1;
      @(posedge clk); #1;
      chk_req = 1'b0;
   endtask

   task automatic expect_irq(input logic e, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
      sb_q.push_back(it);
      chk_req = 1'b1;
      @(posedge clk); #1;
      chk_req = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic pulse(input int idx, input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         evt_in[idx] = 1'b1;
         @(posedge clk); #1;
         evt_in[idx] = 1'b0;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      expect_reg(A_GLOB, 32'h1, "R1 global reset");
      expect_reg(A_CTLA + 4'd0, 32'h1F, "R1 ctlA0 reset");
      expect_reg(A_CNT + 4'd2, 32'h0, "R1 counter2 reset");
      expect_reg(A_CTLB + 4'd1, 32'h0, "R1 ctlB1 reset");
      expect_irq(1'b0, "R1 irq reset");

      // R2 selected event counts, others ignored
      wr(A_CTLA + 4'd0, 32'h0000_0200);
      wr(A_GLOB, 32'h0);
      pulse(2, 3);
      pulse(1, 2);
      expect_reg(A_CNT + 4'd0, 32'd3, "R2 select event 2");

      // R3 local stop
      wr(A_CTLA + 4'd0, 32'h0000_0201);
      pulse(2, 2);
      expect_reg(A_CNT + 4'd0, 32'd3, "R3 local stop holds");

      // R4 privilege freeze
      wr(A_CTLA + 4'd0, 32'h0000_0202);
      priv_sup = 1'b1;
      pulse(2, 2);
      expect_reg(A_CNT + 4'd0, 32'd3, "R4 frozen in supervisor");
      priv_sup = 1'b0;
      pulse(2, 2);
      expect_reg(A_CNT + 4'd0, 32'd5, "R4 counts in user");
      wr(A_CTLA + 4'd0, 32'h0000_0204);
      pulse(2, 1);
      expect_reg(A_CNT + 4'd0, 32'd5, "R4 frozen in user");
      priv_sup = 1'b1;

      // R5 mark freeze
      wr(A_CTLA + 4'd0, 32'h0000_0210);
      mark = 1'b1;
      pulse(2, 2);
      expect_reg(A_CNT + 4'd0, 32'd5, "R5 frozen while mark set");
      mark = 1'b0;
      pulse(2, 1);
      expect_reg(A_CNT + 4'd0, 32'd6, "R5 counts while mark clear");
      wr(A_CTLA + 4'd0, 32'h0000_0208);
      pulse(2, 1);
      expect_reg(A_CNT + 4'd0, 32'd6, "R5 frozen while mark clear");
      wr(A_CTLA + 4'd0, 32'h0000_0200);

      // R6 global freeze
      wr(A_GLOB, 32'h1);
      pulse(2, 3);
      expect_reg(A_CNT + 4'd0, 32'd6, "R6 freeze-all holds");
      wr(A_GLOB, 32'h0);

      // R7 write beats event in the same cycle
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = A_CNT + 4'd0; reg_wdata = 32'd100; evt_in[2] = 1'b1;
      @(posedge clk); #1;
      reg_we = 1'b0; evt_in[2] = 1'b0;
      expect_reg(A_CNT + 4'd0, 32'd100, "R7 write priority");

      // R8 R9 overflow, interrupt and auto freeze
      wr(A_CTLA + 4'd1, 32'h0000_0520);
      wr(A_CNT + 4'd1, 32'h7FFF_FFFE);
      wr(A_GLOB, 32'h6);
      pulse(5, 1);
      expect_reg(A_CNT + 4'd1, 32'h7FFF_FFFF, "R8 below threshold");
      expect_irq(1'b0, "R9 no irq before MSB");
      pulse(5, 1);
      expect_irq(1'b1, "R9 irq on MSB");
      pulse(5, 2);
      pulse(2, 2);
      expect_reg(A_CNT + 4'd1, 32'h8000_0000, "R8 overflowing counter held");
      expect_reg(A_CNT + 4'd0, 32'd100, "R8 other counter held");
      expect_reg(A_GLOB, 32'h7, "R8 freeze-all set by hardware");

      // R9 gating by interrupt enable and condition enable
      wr(A_GLOB, 32'h1);
      expect_irq(1'b0, "R9 irq off with enable clear");
      wr(A_GLOB, 32'h2);
      expect_irq(1'b1, "R9 irq level persists");
      wr(A_CTLA + 4'd1, 32'h0000_0500);
      expect_irq(1'b0, "R9 irq off with condition enable clear");

      // R10 register map
      wr(A_CTLB + 4'd2, 32'hDEAD_BEEF);
      expect_reg(A_CTLB + 4'd2, 32'hDEAD_BEEF, "R10 ctlB storage");
      wr(A_CTLA + 4'd3, 32'hFFFF_FFFF);
      expect_reg(A_CTLA + 4'd3, 32'h0000_0F3F, "R10 ctlA masked");
      expect_reg(A_CTLB + 4'd3, 32'h0, "R10 neighbour untouched");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule